// File: doc/BRIEF.md
# Double-Buffered Quad DAC Command Receiver

This block takes 16-bit command words from a three-wire serial link (an active-low select, a serial clock and a data line) and applies them to a bank of four channels. Each channel holds a staging code and a live code, both 10 bits wide. A command can stage a code, load the live code directly, promote a staged code to live, or apply one of these three actions to every channel together. The live codes feed converters elsewhere on the chip. The staging codes let software prepare all four channels and then switch them in the same cycle.

The serial pins are brought into the system clock domain through two-flop synchronisers, and their edges are found there. The system clock must run at least four times faster than the serial clock. Words that are cut short are dropped. Serial clock edges that arrive after a complete word are ignored until the select line is released and asserted again. Each executed word raises a one-cycle execute strobe, which carries the decoded channel mask and data field. The power-down opcode does not touch the bank. It is handed to a separate power controller as a strobe plus the 12 bits that follow the opcode.

Top module: `quad_dac_cmd_rx`

## Requirements
- R1: A word begins when `cs_n_i` falls. Bits are taken on falling edges of `sclk_i`, most significant bit first. A word executes once its 16th bit is taken. Each executed word raises `exec_stb_o` for exactly one system clock. In that cycle `exec_mask_o` carries the channel mask and `exec_data_o` carries bits 11..2 of the word.
- R2: Bits 15..12 form the opcode. Opcodes 0 to 3 write bits 11..2 into both the staging and the live register of channel 0 to 3 respectively. The mask is one-hot on that channel.
- R3: Opcodes 4 to 7 write only the staging register of channel (opcode minus 4). That channel's live register is unchanged.
- R4: Opcodes 8 to 11 copy the staging register of channel (opcode minus 8) into its live register. No staging register changes.
- R5: Opcode 12 writes the data into the staging and live registers of all four channels. Opcode 13 writes all four staging registers only. Opcode 14 copies every staging register into its live register. The mask for all three is 4'b1111.
- R6: Opcode 15 raises `pd_stb_o` together with `exec_stb_o`, with `exec_mask_o` = 0 and `pd_arg_o` = bits 11..0 of the word. No staging or live register changes.
- R7: If `cs_n_i` rises before the 16th falling `sclk_i` edge of a word, the word is discarded. No strobe is raised and no register changes.
- R8: After a word executes, further falling `sclk_i` edges have no effect until `cs_n_i` goes high and then falls again.
- R9: Synchronous reset `rst` clears all staging and live registers to zero and holds both strobes low.
- R10: `sclk_i` may rest high or low between words. Falling `sclk_i` edges while `cs_n_i` is high shift nothing and do not misalign the next word.
- R11: The staging and live registers change only in a cycle where `exec_stb_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low word select |
| sclk_i | input | 1 | Serial clock, sampled on its falling edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| stage_regs_o | output | 40 | Staging codes, channel i at bits [10*i+9:10*i] |
| live_regs_o | output | 40 | Live codes, channel i at bits [10*i+9:10*i] |
| exec_stb_o | output | 1 | One-cycle pulse per executed word |
| exec_mask_o | output | 4 | Channels addressed by the executed word |
| exec_data_o | output | 10 | Data field of the executed word |
| pd_stb_o | output | 1 | One-cycle pulse for a power-down word |
| pd_arg_o | output | 12 | Low 12 bits of the power-down word |

## Verification
Every one of the 16 opcodes is sent in each of six rounds. Each round uses a different data pattern per opcode, and the resting level of the serial clock alternates between rounds. Because the staged and live codes of a channel are made to differ, the sweep can tell a staging write from a direct write from a promote. Words of every length from zero to fifteen bits show that short words are dropped. A word followed by surplus clocks, and clock activity while deselected, show that alignment holds. A reset in the middle of the run shows the bank clears.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NCH     = 4;
    localparam int DW      = 10;
    localparam int OPW     = 4;
    localparam int TAILW   = 2;
    localparam int FRAME_W = OPW + DW + TAILW;
    localparam int ARGW    = DW + TAILW;
    localparam int SELW    = $clog2(NCH);
    localparam int CNTW    = $clog2(FRAME_W + 1);

    // upper opcode bits pick the action group
    typedef enum logic [1:0] {
        GRP_DIRECT = 2'b00,
        GRP_STAGE  = 2'b01,
        GRP_XFER   = 2'b10,
        GRP_WIDE   = 2'b11
    } grp_e;

    typedef struct packed {
        logic [NCH-1:0]  mask;
        logic            wr_stage;
        logic            wr_live;
        logic            promote;
        logic            pd;
        logic [DW-1:0]   data;
        logic [ARGW-1:0] arg;
    } cmd_t;

    function automatic logic [NCH-1:0] onehot_sel(input logic [SELW-1:0] sel);
        logic [NCH-1:0] m;
        m = '0;
        m[sel] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;
    logic [WIDTH-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= {STAGES{RST_VAL}};
            prev <= RST_VAL;
        end else begin
            pipe[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl_o  = pipe[STAGES-1];
    assign fall_o = prev & ~pipe[STAGES-1];

endmodule

// File: rtl/qdac_deser.sv
module qdac_deser
    import qdac_pkg::*;
#(
    parameter int WORD_W = FRAME_W,
    parameter int CW     = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_lvl_i,
    input  logic              cs_fall_i,
    input  logic              sclk_fall_i,
    input  logic              sdi_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic              armed;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            cnt        <= '0;
            shreg      <= '0;
            word_vld_o <= 1'b0;
        end else begin
            word_vld_o <= 1'b0;
            if (cs_lvl_i) begin
                // deselected: any partial word is dropped
                armed <= 1'b0;
                cnt   <= '0;
            end else if (cs_fall_i) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && sclk_fall_i) begin
                shreg <= {shreg[WORD_W-2:0], sdi_i};
                if (cnt == LAST) begin
                    armed      <= 1'b0;
                    cnt        <= '0;
                    word_vld_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign word_o = shreg;

endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  logic [FRAME_W-1:0] word_i,
    output cmd_t               cmd_o
);

    logic [OPW-1:0]  op;
    logic [SELW-1:0] sel;
    grp_e            grp;

    assign op  = word_i[FRAME_W-1 -: OPW];
    assign sel = op[SELW-1:0];
    assign grp = grp_e'(op[OPW-1 -: 2]);

    always_comb begin
        cmd_o          = '0;
        cmd_o.data     = word_i[FRAME_W-OPW-1 -: DW];
        cmd_o.arg      = word_i[ARGW-1:0];
        unique case (grp)
            GRP_DIRECT: begin
                cmd_o.mask     = onehot_sel(sel);
                cmd_o.wr_stage = 1'b1;
                cmd_o.wr_live  = 1'b1;
            end
            GRP_STAGE: begin
                cmd_o.mask     = onehot_sel(sel);
                cmd_o.wr_stage = 1'b1;
            end
            GRP_XFER: begin
                cmd_o.mask    = onehot_sel(sel);
                cmd_o.promote = 1'b1;
            end
            GRP_WIDE: begin
                unique case (op[1:0])
                    2'b00: begin
                        cmd_o.mask     = '1;
                        cmd_o.wr_stage = 1'b1;
                        cmd_o.wr_live  = 1'b1;
                    end
                    2'b01: begin
                        cmd_o.mask     = '1;
                        cmd_o.wr_stage = 1'b1;
                    end
                    2'b10: begin
                        cmd_o.mask    = '1;
                        cmd_o.promote = 1'b1;
                    end
                    default: begin
                        cmd_o.pd = 1'b1;
                    end
                endcase
            end
            default: cmd_o = '0;
        endcase
    end

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int CH = NCH,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  cmd_t          cmd_i,
    output logic [CH*W-1:0] stage_o,
    output logic [CH*W-1:0] live_o
);

    for (genvar i = 0; i < CH; i++) begin : g_ch
        logic [W-1:0] stage_q;
        logic [W-1:0] live_q;
        logic         hit;

        assign hit = go_i && cmd_i.mask[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
                live_q  <= '0;
            end else if (hit) begin
                if (cmd_i.wr_stage) stage_q <= cmd_i.data;
                if (cmd_i.wr_live)       live_q <= cmd_i.data;
                else if (cmd_i.promote)  live_q <= stage_q;
            end
        end

        assign stage_o[i*W +: W] = stage_q;
        assign live_o[i*W +: W]  = live_q;
    end

endmodule

// File: rtl/quad_dac_cmd_rx.sv
module quad_dac_cmd_rx
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    output logic [NCH*DW-1:0]   stage_regs_o,
    output logic [NCH*DW-1:0]   live_regs_o,
    output logic                exec_stb_o,
    output logic [NCH-1:0]      exec_mask_o,
    output logic [DW-1:0]       exec_data_o,
    output logic                pd_stb_o,
    output logic [ARGW-1:0]     pd_arg_o
);

    // pin order inside the synchroniser vector
    localparam int P_CS   = 2;
    localparam int P_SCLK = 1;
    localparam int P_SDI  = 0;

    logic [2:0]         pin_lvl;
    logic [2:0]         pin_fall;
    logic               word_vld;
    logic [FRAME_W-1:0] word;
    cmd_t               cmd;

    qdac_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b111)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({cs_n_i, sclk_i, sdi_i}),
        .lvl_o  (pin_lvl),
        .fall_o (pin_fall)
    );

    qdac_deser #(
        .WORD_W (FRAME_W)
    ) u_deser (
        .clk         (clk),
        .rst         (rst),
        .cs_lvl_i    (pin_lvl[P_CS]),
        .cs_fall_i   (pin_fall[P_CS]),
        .sclk_fall_i (pin_fall[P_SCLK]),
        .sdi_i       (pin_lvl[P_SDI]),
        .word_vld_o  (word_vld),
        .word_o      (word)
    );

    qdac_decode u_dec (
        .word_i (word),
        .cmd_o  (cmd)
    );

    qdac_bank #(
        .CH (NCH),
        .W  (DW)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .go_i    (word_vld),
        .cmd_i   (cmd),
        .stage_o (stage_regs_o),
        .live_o  (live_regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_stb_o  <= 1'b0;
            exec_mask_o <= '0;
            exec_data_o <= '0;
            pd_stb_o    <= 1'b0;
            pd_arg_o    <= '0;
        end else begin
            exec_stb_o <= word_vld;
            pd_stb_o   <= word_vld && cmd.pd;
            if (word_vld) begin
                exec_mask_o <= cmd.mask;
                exec_data_o <= cmd.data;
                if (cmd.pd) pd_arg_o <= cmd.arg;
            end
        end
    end

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
    import qdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NCH*DW-1:0] stage_regs_o,
    input logic [NCH*DW-1:0] live_regs_o,
    input logic              exec_stb_o,
    input logic [NCH-1:0]    exec_mask_o,
    input logic              pd_stb_o
);

    // R1: strobe lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        exec_stb_o |=> !exec_stb_o);

    // R2/R5: a data command addresses one channel or all of them
    a_r5_mask_shape: assert property (@(posedge clk) disable iff (rst)
        (exec_stb_o && !pd_stb_o) |-> ($onehot0(exec_mask_o) && exec_mask_o != '0) || (exec_mask_o == '1));

    // R6: power-down has empty mask and rides on the execute strobe
    a_r6_pd_mask: assert property (@(posedge clk) disable iff (rst)
        pd_stb_o |-> (exec_stb_o && exec_mask_o == '0));

    // R6: power-down leaves the bank alone
    a_r6_pd_keeps_bank: assert property (@(posedge clk) disable iff (rst)
        pd_stb_o |-> ($stable(live_regs_o) && $stable(stage_regs_o)));

    // R11: no register motion without an executed word
    a_r11_quiet_bank: assert property (@(posedge clk) disable iff (rst)
        !exec_stb_o |-> ($stable(live_regs_o) && $stable(stage_regs_o)));

    // R9: bank is clear right after reset
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_regs_o == '0 && stage_regs_o == '0 && !exec_stb_o));

endmodule

bind quad_dac_cmd_rx qdac_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stage_regs_o (stage_regs_o),
    .live_regs_o  (live_regs_o),
    .exec_stb_o   (exec_stb_o),
    .exec_mask_o  (exec_mask_o),
    .pd_stb_o     (pd_stb_o)
);

// File: tb/tb_quad_dac_cmd_rx.sv
module tb_quad_dac_cmd_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [39:0] stage_regs, live_regs;
    logic        exec_stb, pd_stb;
    logic [3:0]  exec_mask;
    logic [9:0]  exec_data;
    logic [11:0] pd_arg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          stb_cnt = 0;
    int          pd_cnt  = 0;
    logic [3:0]  last_mask = '0;
    logic [9:0]  last_data = '0;
    logic [11:0] last_arg  = '0;

    logic [9:0] m_stage [4];
    logic [9:0] m_live  [4];

    always #4 clk = ~clk;

    quad_dac_cmd_rx dut (
        .clk          (clk),
        .rst          (rst),
        .cs_n_i       (cs_n),
        .sclk_i       (sclk),
        .sdi_i        (sdi),
        .stage_regs_o (stage_regs),
        .live_regs_o  (live_regs),
        .exec_stb_o   (exec_stb),
        .exec_mask_o  (exec_mask),
        .exec_data_o  (exec_data),
        .pd_stb_o     (pd_stb),
        .pd_arg_o     (pd_arg)
    );

    always @(negedge clk) begin
        if (exec_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_mask <= exec_mask;
            last_data <= exec_data;
        end
        if (pd_stb) begin
            pd_cnt   <= pd_cnt + 1;
            last_arg <= pd_arg;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [39:0] pack(input bit live);
        logic [39:0] v;
        for (int i = 0; i < 4; i++) v[i*10 +: 10] = live ? m_live[i] : m_stage[i];
        return v;
    endfunction

    function automatic logic [3:0] exp_mask(input logic [3:0] op);
        if (op < 4'd12) return 4'b0001 << op[1:0];
        if (op == 4'd15) return 4'b0000;
        return 4'b1111;
    endfunction

    task automatic model_apply(input logic [15:0] w);
        logic [3:0] op;
        logic [9:0] d;
        op = w[15:12];
        d  = w[11:2];
        for (int i = 0; i < 4; i++) begin
            if (exp_mask(op)[i]) begin
                if (op < 4'd4 || op == 4'd12) begin
                    m_stage[i] = d; m_live[i] = d;
                end else if (op < 4'd8 || op == 4'd13) begin
                    m_stage[i] = d;
                end else begin
                    m_live[i] = m_stage[i];
                end
            end
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input bit idle_hi);
        sclk = idle_hi;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[15 - (i % 16)];
            wait_clk(2);
            if (idle_hi) begin
                sclk = 1'b0; wait_clk(4); sclk = 1'b1; wait_clk(4);
            end else begin
                sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
            end
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic check_bank(input string tag);
        chk({tag, " live"},  {24'd0, live_regs},  {24'd0, pack(1'b1)});
        chk({tag, " stage"}, {24'd0, stage_regs}, {24'd0, pack(1'b0)});
    endtask

    task automatic full_word(input logic [15:0] w, input bit idle_hi, input string tag);
        int s0, p0;
        s0 = stb_cnt;
        p0 = pd_cnt;
        send(w, 16, idle_hi);
        model_apply(w);
        chk({tag, " R1 strobe count"}, 64'(stb_cnt - s0), 64'd1);
        chk({tag, " R1 mask"}, {60'd0, last_mask}, {60'd0, exp_mask(w[15:12])});
        chk({tag, " R1 data"}, {54'd0, last_data}, {54'd0, w[11:2]});
        if (w[15:12] == 4'd15) begin
            chk({tag, " R6 pd count"}, 64'(pd_cnt - p0), 64'd1);
            chk({tag, " R6 pd arg"}, {52'd0, last_arg}, {52'd0, w[11:0]});
        end else begin
            chk({tag, " R6 no pd"}, 64'(pd_cnt - p0), 64'd0);
        end
        check_bank(tag);
    endtask

    function automatic string op_tag(input logic [3:0] op);
        if (op < 4'd4)  return "R2";
        if (op < 4'd8)  return "R3";
        if (op < 4'd12) return "R4";
        if (op < 4'd15) return "R5";
        return "R6";
    endfunction

    initial begin
        for (int i = 0; i < 4; i++) begin m_stage[i] = '0; m_live[i] = '0; end
        wait_clk(6);
        rst = 1'b0;
        wait_clk(2);
        // R9: reset state
        check_bank("R9 after reset");
        chk("R9 strobe low", {63'd0, exec_stb}, 64'd0);
        chk("R9 pd strobe low", {63'd0, pd_stb}, 64'd0);

        // sweep every opcode over six data rounds, both idle levels (R10)
        for (int r = 0; r < 6; r++) begin
            for (int op = 0; op < 16; op++) begin
                logic [9:0]  d;
                logic [15:0] w;
                d = 10'((op * 157 + r * 311 + 37) ^ (r * 64));
                w = {4'(op), d, 2'(op + r)};
                full_word(w, r[0], r[0] ? {op_tag(4'(op)), " R10 idle-high"} : op_tag(4'(op)));
            end
        end

        // R7: every short length is dropped
        for (int n = 0; n < 16; n++) begin
            int s0;
            s0 = stb_cnt;
            send({4'd12, 10'h1A5, 2'b00}, n, n[0]);
            chk($sformatf("R7 short %0d bits strobe", n), 64'(stb_cnt - s0), 64'd0);
            check_bank("R7 short word");
        end

        // R8: surplus clocks after a full word
        begin
            int s0;
            logic [15:0] w;
            w = {4'd12, 10'h0F3, 2'b00};
            s0 = stb_cnt;
            send(w, 23, 1'b0);
            model_apply(w);
            chk("R8 surplus clocks single strobe", 64'(stb_cnt - s0), 64'd1);
            check_bank("R8 surplus clocks");
            full_word({4'd5, 10'h2C4, 2'b00}, 1'b1, "R8 next word aligned");
        end

        // R10: clock activity while deselected
        begin
            int s0;
            s0 = stb_cnt;
            for (int k = 0; k < 10; k++) begin
                sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
            end
            wait_clk(6);
            chk("R10 deselected clocks no strobe", 64'(stb_cnt - s0), 64'd0);
            check_bank("R10 deselected clocks");
            full_word({4'd9, 10'h3C1, 2'b00}, 1'b0, "R10 R4 after idle clocks");
        end

        // R9: reset in mid-run
        full_word({4'd12, 10'h3FF, 2'b00}, 1'b0, "R5 preload");
        @(negedge clk) rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin m_stage[i] = '0; m_live[i] = '0; end
        wait_clk(2);
        check_bank("R9 mid-run reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule